// File: doc/BRIEF.md
# Programmable Maximal-Length Sequence Generator

This block produces pseudo-random chips from a linear feedback shift register whose degree, between 2 and 8 stages, and whose feedback polynomial are chosen at run time. The polynomial arrives as a coefficient word that matches the usual octal table notation: bit i of the word is the coefficient of x^i. A primitive polynomial gives a sequence that repeats every 2^n − 1 chips. A mode input selects the reciprocal polynomial instead. That polynomial also yields a maximal sequence, different from the first.

The register is in Fibonacci form. The XOR of the tapped stages enters at the low end, and the chip is the highest active stage. Each enable pulse advances the register by one step. The chip is presented as a 0/1 bit and as a two-bit signed value, with 0 shown as +1 and 1 shown as −1. Successive chips are also gathered six at a time into words from 0 to 63, which can drive a 64-bin frequency hopper. A one-cycle marker flags each time the register comes back to its starting value.

Configuration is captured only on a load strobe. A load also reseeds the register and restarts the word packer. An all-zero seed is replaced by 1, and any step that would leave the register all-zero lands on 1 instead, so the register can never lock up.

Top module: `mseq_gen`

## Requirements
- R1: After reset, the block runs a degree-2 register with polynomial 1 + x + x^2 and state 1. In that state chip is 0, chip_pm is +1, and hop_valid and wrap are 0.
- R2: Changes on deg_in, poly_in, recip_in and seed_in have no effect while load is low. A load takes priority over en.
- R3: On load, the seed is masked to the degree's low bits. If the masked seed is zero, the value 1 is used instead.
- R4: With recip_in = 0 and degree n, the chip sequence a0, a1, … starts with a_i = seed bit n−1−i and follows a_{k+n} = XOR over i < n of poly_in[i]·a_{k+i}, where poly_in bit i is the coefficient of x^i.
- R5: With recip_in = 1, the coefficient poly_in[i] in R4 is replaced by poly_in[n−i].
- R6: wrap is high for one cycle after each step that returns the register to its loaded seed. With a primitive polynomial, the first wrap comes exactly 2^n − 1 steps after the load.
- R7: The register never holds all zeros. A step whose result would be zero gives state 1 instead.
- R8: chip_pm is 2'b01 (+1) when chip is 0 and 2'b11 (−1) when chip is 1.
- R9: After every sixth step counted from a load, hop_valid pulses for one cycle. hop_word then holds those six chips, with the earliest chip in bit 5.
- R10: While en and load are both low, the state does not change, and hop_valid and wrap stay 0.
- R11: A deg_in below 2 is treated as 2, and a deg_in above 8 is treated as 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Advance the register by one step |
| load | input | 1 | Capture degree, polynomial, mode and seed |
| deg_in | input | 4 | Requested degree (clamped to 2..8) |
| poly_in | input | 9 | Polynomial coefficients, bit i is the coefficient of x^i |
| recip_in | input | 1 | Use the reciprocal polynomial |
| seed_in | input | 8 | Starting state |
| chip | output | 1 | Current chip bit |
| chip_pm | output | 2 | Signed chip, +1 or −1 |
| hop_word | output | 6 | Last completed group of six chips |
| hop_valid | output | 1 | One-cycle strobe when a new hop_word is ready |
| wrap | output | 1 | One-cycle marker when the register returns to its seed |

## Verification
The hardest condition to reach is the lockup guard. No primitive polynomial can ever produce the zero state from a nonzero one. To reach it, the bench loads a non-primitive coefficient word that has no constant term (x^2 + x^5) together with a seed whose only set bit is the top stage. The very next step would then clear the register. The chips that follow show whether the guard put 1 in its place. The full periods of the degree-8 polynomials are also walked, in both normal and reciprocal form. This confirms that the first wrap comes only after 255 steps, and that the hop-word phase survives a reload made in the middle of a word.

// File: rtl/mseq_gen.sv
module mseq_gen #(
  parameter int MAX_DEG = 8,
  parameter int HOP_W   = 6,
  localparam int DW = $clog2(MAX_DEG + 1),
  localparam int CW = $clog2(HOP_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                load,
  input  logic [DW-1:0]       deg_in,
  input  logic [MAX_DEG:0]    poly_in,
  input  logic                recip_in,
  input  logic [MAX_DEG-1:0]  seed_in,
  output logic                chip,
  output logic signed [1:0]   chip_pm,
  output logic [HOP_W-1:0]    hop_word,
  output logic                hop_valid,
  output logic                wrap
);

  logic [DW-1:0]      deg_c;
  logic [MAX_DEG-1:0] mask_c, taps_c, seed_m, seed_c;
  logic [MAX_DEG-1:0] sr, seed_q, taps_q, mask_q, nxt_raw, nxt;
  logic [HOP_W-1:0]   hop_acc;
  logic [CW-1:0]      hop_cnt;
  logic               fb;

  assign deg_c = (deg_in < DW'(2))       ? DW'(2) :
                 (deg_in > DW'(MAX_DEG)) ? DW'(MAX_DEG) : deg_in;

  always_comb begin
    for (int k = 0; k < MAX_DEG; k++) begin
      mask_c[k] = (k < int'(deg_c));
      taps_c[k] = 1'b0;
      if (k < int'(deg_c))
        taps_c[k] = recip_in ? poly_in[k+1] : poly_in[int'(deg_c) - 1 - k];
    end
  end

  assign seed_m  = seed_in & mask_c;
  assign seed_c  = (|seed_m) ? seed_m : MAX_DEG'(1);

  assign fb      = ^(sr & taps_q);
  assign nxt_raw = {sr[MAX_DEG-2:0], fb} & mask_q;
  assign nxt     = (|nxt_raw) ? nxt_raw : MAX_DEG'(1);

  assign chip    = |(sr & mask_q & ~(mask_q >> 1));
  assign chip_pm = {chip, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr        <= MAX_DEG'(1);
      seed_q    <= MAX_DEG'(1);
      taps_q    <= MAX_DEG'(3);
      mask_q    <= MAX_DEG'(3);
      hop_acc   <= '0;
      hop_cnt   <= '0;
      hop_word  <= '0;
      hop_valid <= 1'b0;
      wrap      <= 1'b0;
    end else if (load) begin
      sr        <= seed_c;
      seed_q    <= seed_c;
      taps_q    <= taps_c;
      mask_q    <= mask_c;
      hop_cnt   <= '0;
      hop_valid <= 1'b0;
      wrap      <= 1'b0;
    end else if (en) begin
      sr      <= nxt;
      wrap    <= (nxt == seed_q);
      hop_acc <= {hop_acc[HOP_W-2:0], chip};
      if (hop_cnt == CW'(HOP_W - 1)) begin
        hop_cnt   <= '0;
        hop_word  <= {hop_acc[HOP_W-2:0], chip};
        hop_valid <= 1'b1;
      end else begin
        hop_cnt   <= hop_cnt + CW'(1);
        hop_valid <= 1'b0;
      end
    end else begin
      hop_valid <= 1'b0;
      wrap      <= 1'b0;
    end
  end

endmodule

// File: rtl/mseq_gen_chk.sv
module mseq_gen_chk #(
  parameter int MAX_DEG = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               en,
  input logic               load,
  input logic               chip,
  input logic signed [1:0]  chip_pm,
  input logic               hop_valid,
  input logic               wrap,
  input logic [MAX_DEG-1:0] state
);

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load) |=> ($stable(state) && !hop_valid && !wrap)); // R10

  AST_SIGN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_pm == 2'sd1 && !chip) || (chip_pm == -2'sd1 && chip)); // R8

  AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0); // R7

  AST_HOP_FROM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hop_valid) |-> ($past(en) && !$past(load))); // R9

  AST_HOP_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    hop_valid |=> !hop_valid); // R9

  AST_WRAP_FROM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wrap) |-> ($past(en) && !$past(load))); // R6

  AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!hop_valid && !wrap)); // R2

endmodule

bind mseq_gen mseq_gen_chk #(.MAX_DEG(MAX_DEG)) chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .load(load), .chip(chip),
  .chip_pm(chip_pm), .hop_valid(hop_valid), .wrap(wrap), .state(sr)
);

// File: tb/mseq_gen_tb_top.sv
`timescale 1ns/1ps
module mseq_gen_tb_top;
  localparam int CLK_NS = 20;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, load = 1'b0, recip_in = 1'b0;
  logic [3:0] deg_in = 4'd2;
  logic [8:0] poly_in = 9'o7;
  logic [7:0] seed_in = 8'h01;
  logic chip, hop_valid, wrap;
  logic signed [1:0] chip_pm;
  logic [5:0] hop_word;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic mbits [0:599];

  always #(CLK_NS/2) clk = ~clk;

  mseq_gen dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .load(load), .deg_in(deg_in),
    .poly_in(poly_in), .recip_in(recip_in), .seed_in(seed_in),
    .chip(chip), .chip_pm(chip_pm), .hop_word(hop_word),
    .hop_valid(hop_valid), .wrap(wrap)
  );

  // deg_in, poly_in (octal), recip_in, seed_in
  localparam logic [21:0] VEC [0:9] = '{
    {4'd2, 9'o7,   1'b0, 8'h01},
    {4'd3, 9'o13,  1'b0, 8'h05},
    {4'd4, 9'o23,  1'b1, 8'h09},
    {4'd5, 9'o45,  1'b0, 8'h13},
    {4'd5, 9'o45,  1'b1, 8'h00},
    {4'd6, 9'o103, 1'b0, 8'h2A},
    {4'd7, 9'o211, 1'b1, 8'h7F},
    {4'd8, 9'o435, 1'b0, 8'hA5},
    {4'd8, 9'o551, 1'b1, 8'h00},
    {4'd5, 9'o75,  1'b0, 8'hFF}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  function automatic int clamp_deg(input int d);
    return (d < 2) ? 2 : (d > 8) ? 8 : d;
  endfunction

  function automatic int eff_seed(input int n, input int s);
    int m = s & ((1 << n) - 1);
    return (m == 0) ? 1 : m;
  endfunction

  task automatic build(input int n, input logic [8:0] p, input bit rc, input int s, input int len);
    for (int i = 0; i < n; i++) mbits[i] = s[n-1-i];
    for (int k = 0; k + n < len; k++) begin
      logic acc = 1'b0;
      for (int i = 0; i < n; i++)
        acc ^= (rc ? p[n-i] : p[i]) & mbits[k+i];
      mbits[k+n] = acc;
    end
  endtask

  task automatic do_load(input logic [3:0] d, input logic [8:0] p, input bit rc, input logic [7:0] s);
    @(negedge clk);
    deg_in = d; poly_in = p; recip_in = rc; seed_in = s; load = 1'b1; en = 1'b0;
    @(negedge clk);
    load = 1'b0;
    deg_in = 4'd3; poly_in = 9'h1FF; recip_in = ~rc; seed_in = 8'h55;
  endtask

  task automatic run_chk(input int n, input int steps, input string tag);
    int per = (1 << n) - 1;
    for (int k = 0; k < steps; k++) begin
      chk(chip == mbits[k], {tag, " R4/R5 chip"}, chip, mbits[k]);
      chk(chip_pm == (mbits[k] ? -2'sd1 : 2'sd1), "R8 chip_pm", chip_pm, mbits[k] ? -1 : 1);
      en = 1'b1;
      @(negedge clk);
      en = 1'b0;
      chk(wrap == ((k + 1) % per == 0), {tag, " R6 wrap"}, wrap, ((k + 1) % per == 0));
      chk(hop_valid == ((k + 1) % 6 == 0), "R9 hop_valid", hop_valid, ((k + 1) % 6 == 0));
      if ((k + 1) % 6 == 0) begin
        int w = 0;
        for (int b = 0; b < 6; b++) w = (w << 1) | int'(mbits[k - 5 + b]);
        chk(int'(hop_word) == w, "R9 hop_word", hop_word, w);
      end
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 200000) begin
        chk(1'b0, "watchdog", cyc, 200000);
        summary();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(chip == 1'b0, "R1 chip", chip, 0);
    chk(chip_pm == 2'sd1, "R1 chip_pm", chip_pm, 1);
    chk(!hop_valid && !wrap, "R1 strobes", hop_valid + wrap, 0);
    rst_n = 1'b1;
    @(negedge clk);
    build(2, 9'o7, 1'b0, 1, 40);
    run_chk(2, 7, "R1");

    for (int v = 0; v < 10; v++) begin
      logic [21:0] e = VEC[v];
      int n = clamp_deg(int'(e[21:18]));
      int s = eff_seed(n, int'(e[7:0]));
      do_load(e[21:18], e[17:9], e[8], e[7:0]);
      chk(chip == s[n-1], "R3 seed", chip, s[n-1]);
      build(n, e[17:9], e[8], s, 600);
      run_chk(n, ((1 << n) - 1) + 4 + v, "R2");
    end

    do_load(4'd5, 9'o45, 1'b0, 8'h13);
    build(5, 9'o45, 1'b0, 8'h13, 80);
    run_chk(5, 2, "R2");
    repeat (3) begin
      @(negedge clk);
      chk(chip == mbits[2], "R10 hold chip", chip, mbits[2]);
      chk(!hop_valid && !wrap, "R10 strobes", hop_valid + wrap, 0);
    end

    @(negedge clk);
    deg_in = 4'd5; poly_in = 9'o45; seed_in = 8'h13; load = 1'b1; en = 1'b1;
    @(negedge clk);
    load = 1'b0; en = 1'b0;
    chk(chip == mbits[0], "R2 load over en", chip, mbits[0]);

    do_load(4'd5, 9'o44, 1'b0, 8'h10);
    chk(chip == 1'b1, "R7 start", chip, 1);
    for (int k = 1; k <= 5; k++) begin
      en = 1'b1;
      @(negedge clk);
      en = 1'b0;
      chk(chip == (k == 5), "R7 guard", chip, (k == 5));
      chk(wrap == 1'b0, "R7 wrap", wrap, 0);
    end

    do_load(4'd0, 9'o7, 1'b0, 8'h03);
    build(2, 9'o7, 1'b0, 3, 40);
    run_chk(2, 6, "R11");
    do_load(4'd15, 9'o435, 1'b0, 8'h01);
    build(8, 9'o435, 1'b0, 1, 600);
    run_chk(8, 260, "R11");

    summary();
  end
endmodule